// File: doc/BRIEF.md
# Uncached Word-Pair Store Merger

This block sits between a core's store path and the system bus. Each store it receives is a single 32-bit word with an address, a flag saying whether the access bypasses the cache, and a flag saying whether the store belongs to a multiple-word store sequence. The block turns every store into one bus write. The one exception is a pair of uncached multiple-word stores that fill the two halves of one aligned 8-byte double word. That pair is merged into a single 8-byte write.

A store that could begin such a pair is parked in a one-entry holding stage. It waits there only until the output stage next has room. At that point it either leaves together with its partner, if the partner is presented in that same cycle, or it leaves alone as a 4-byte write. Every other store is issued directly. Writes reach the bus in the order the stores were accepted. The bus side uses a valid/ready handshake and carries an address, a 3-bit size code, a 64-bit data bus and eight byte-lane enables. Byte lanes follow big-endian memory order, so lower-addressed bytes sit in the upper data bits.

An optional self-check output watches every issued transfer and raises a flag if a transfer's byte span runs across a 32-byte coherency block.

Top module: `cis_store_combiner`

## Requirements
- R1: After reset, `bus_valid` is low, no store is held, and `st_ready` is high.
- R2: Two stores can merge into one transfer only under all of these conditions:
  - both are uncached multiple-word stores;
  - the first has address bit 2 equal to 0 and is held;
  - the second has the first's word address plus 4 and is presented in the cycle the held word is released.
  The merged transfer has size code 3'b000, the first store's address, data {first, second} on bus_data[63:0], and lanes 8'hFF.
- R3: A store that is cached, or that is not part of a multiple-word store, is never merged and leaves as a 4-byte write.
- R4: A 4-byte write has size code 3'b100 and an address with bits [1:0] cleared. At address bit 2 = 0 its data is on bus_data[63:32] with lanes 8'hF0. At bit 2 = 1 its data is on bus_data[31:0] with lanes 8'h0F. Unused lanes carry zero.
- R5: A store at an odd word slot (address bit 2 = 1) is never held and is issued alone, even if it is an uncached multiple-word store.
- R6: A held word is released in the first cycle in which the output stage has room. If no partner is presented in that cycle, it leaves as a 4-byte write, and `st_ready` is low during that release cycle.
- R7: Transfers leave in the order their stores were accepted, and the bus outputs match a cycle-accurate reference on every cycle.
- R8: While `bus_valid` is high and `bus_ready` is low, the transfer is held on the bus unchanged.
- R9: No transfer's byte span crosses a 32-byte aligned boundary. `span_err` rises only when `chk_en` is high and a crossing transfer is valid.
- R10: While the output stage is occupied and `bus_ready` is low, `st_ready` is low.

Size codes used throughout: 3'b000 means 8 bytes and 3'b100 means 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | 32 | Store byte address (bits [1:0] ignored) |
| st_data | input | 32 | Store word |
| st_uncached | input | 1 | Store bypasses the cache |
| st_multi | input | 1 | Store is part of a multiple-word store |
| bus_valid | output | 1 | Bus write presented |
| bus_ready | input | 1 | Bus accepts the write |
| bus_addr | output | 32 | Write start address |
| bus_size | output | 3 | Size code (000 = 8 bytes, 100 = 4 bytes) |
| bus_data | output | 64 | Write data, big-endian lane order |
| bus_lanes | output | 8 | Lane enables, bit i covers bus_data[8i+7:8i] |
| chk_en | input | 1 | Enables the boundary self-check |
| span_err | output | 1 | A valid transfer crosses a 32-byte boundary |

## Verification
A holding stage stuck full or wrongly cleared shows up in one of two ways. Either a word vanishes, or it leaves late as a 4-byte write where an 8-byte one was due. `st_ready` then disagrees with the reference in the same cycle, and the recorded transfer list differs once the scenario drains. A bad partner match shows in the size code and lane enables on the very transfer it produces. A broken output register shows as `bus_valid` or stalled fields changing during backpressure, within one clock.

// File: rtl/cis_pkg.sv
package cis_pkg;

    localparam int unsigned ADDR_W      = 32;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned BUS_W       = 2 * WORD_W;
    localparam int unsigned LANES       = BUS_W / 8;
    localparam int unsigned HALF_LANES  = LANES / 2;
    localparam int unsigned BLOCK_BYTES = 32;
    localparam int unsigned BLOCK_LSB   = $clog2(BLOCK_BYTES);

    localparam logic [2:0] SZ_DWORD = 3'b000;
    localparam logic [2:0] SZ_WORD  = 3'b100;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } word_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [2:0]        size;
        logic [BUS_W-1:0]  data;
        logic [LANES-1:0]  lanes;
    } xfer_t;

    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:2], 2'b00};
    endfunction

    // Byte count of a size code: 000 stands for the full bus width.
    function automatic logic [3:0] size_bytes(input logic [2:0] s);
        return (s == SZ_DWORD) ? 4'd8 : {1'b0, s};
    endfunction

    function automatic xfer_t single_xfer(input word_t w);
        xfer_t x;
        x.addr = word_align(w.addr);
        x.size = SZ_WORD;
        if (w.addr[2]) begin
            x.data  = {{WORD_W{1'b0}}, w.data};
            x.lanes = {{HALF_LANES{1'b0}}, {HALF_LANES{1'b1}}};
        end else begin
            x.data  = {w.data, {WORD_W{1'b0}}};
            x.lanes = {{HALF_LANES{1'b1}}, {HALF_LANES{1'b0}}};
        end
        return x;
    endfunction

    function automatic xfer_t pair_xfer(input word_t lo, input logic [WORD_W-1:0] hi);
        xfer_t x;
        x.addr  = word_align(lo.addr);
        x.size  = SZ_DWORD;
        x.data  = {lo.data, hi};
        x.lanes = {LANES{1'b1}};
        return x;
    endfunction

endpackage

// File: rtl/cis_hold_stage.sv
module cis_hold_stage
    import cis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [WORD_W-1:0] st_data,
    input  logic              st_uncached,
    input  logic              st_multi,
    input  logic              out_free,
    output logic              st_ready,
    output logic              push,
    output xfer_t             push_xfer
);

    logic  hold_v;
    word_t hold_q;
    word_t incoming;
    logic  combinable;
    logic  starts_pair;
    logic  is_partner;
    logic  load;
    logic  clear;

    assign incoming    = '{addr: word_align(st_addr), data: st_data};
    assign combinable  = st_valid && st_uncached && st_multi;
    assign starts_pair = combinable && !st_addr[2];
    assign is_partner  = hold_v && combinable &&
                         (incoming.addr == hold_q.addr + ADDR_W'(4));

    assign st_ready = out_free && (!hold_v || is_partner);

    always_comb begin
        push      = 1'b0;
        push_xfer = '0;
        load      = 1'b0;
        clear     = 1'b0;
        if (out_free) begin
            if (hold_v) begin
                push      = 1'b1;
                clear     = 1'b1;
                push_xfer = is_partner ? pair_xfer(hold_q, st_data)
                                       : single_xfer(hold_q);
            end else if (st_valid) begin
                if (starts_pair) begin
                    load = 1'b1;
                end else begin
                    push      = 1'b1;
                    push_xfer = single_xfer(incoming);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
            hold_q <= '0;
        end else if (load) begin
            hold_v <= 1'b1;
            hold_q <= incoming;
        end else if (clear) begin
            hold_v <= 1'b0;
        end
    end

endmodule

// File: rtl/cis_issue_reg.sv
module cis_issue_reg
    import cis_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  xfer_t push_xfer,
    input  logic  bus_ready,
    output logic  bus_valid,
    output xfer_t bus_xfer,
    output logic  out_free
);

    assign out_free = !bus_valid || bus_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_valid <= 1'b0;
            bus_xfer  <= '0;
        end else if (out_free) begin
            bus_valid <= push;
            if (push) begin
                bus_xfer <= push_xfer;
            end
        end
    end

endmodule

// File: rtl/cis_span_check.sv
module cis_span_check
    import cis_pkg::*;
(
    input  logic              enable,
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output logic              crossed
);

    logic [ADDR_W:0] last_byte;

    assign last_byte = {1'b0, addr} + {{(ADDR_W-3){1'b0}}, size_bytes(size)}
                       - (ADDR_W+1)'(1);
    assign crossed   = enable && valid &&
                       (last_byte[ADDR_W:BLOCK_LSB] != {1'b0, addr[ADDR_W-1:BLOCK_LSB]});

endmodule

// File: rtl/cis_store_combiner.sv
module cis_store_combiner
    import cis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [WORD_W-1:0] st_data,
    input  logic              st_uncached,
    input  logic              st_multi,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_size,
    output logic [BUS_W-1:0]  bus_data,
    output logic [LANES-1:0]  bus_lanes,
    input  logic              chk_en,
    output logic              span_err
);

    logic  out_free;
    logic  push;
    xfer_t push_xfer;
    xfer_t bus_xfer;

    cis_hold_stage u_hold (
        .clk        (clk),
        .rst        (rst),
        .st_valid   (st_valid),
        .st_addr    (st_addr),
        .st_data    (st_data),
        .st_uncached(st_uncached),
        .st_multi   (st_multi),
        .out_free   (out_free),
        .st_ready   (st_ready),
        .push       (push),
        .push_xfer  (push_xfer)
    );

    cis_issue_reg u_issue (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_xfer(push_xfer),
        .bus_ready(bus_ready),
        .bus_valid(bus_valid),
        .bus_xfer (bus_xfer),
        .out_free (out_free)
    );

    assign bus_addr  = bus_xfer.addr;
    assign bus_size  = bus_xfer.size;
    assign bus_data  = bus_xfer.data;
    assign bus_lanes = bus_xfer.lanes;

    cis_span_check u_span (
        .enable (chk_en),
        .valid  (bus_valid),
        .addr   (bus_xfer.addr),
        .size   (bus_xfer.size),
        .crossed(span_err)
    );

endmodule

// File: rtl/cis_store_combiner_chk.sv
module cis_store_combiner_chk
    import cis_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              st_valid,
    input logic              st_ready,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [2:0]        bus_size,
    input logic [BUS_W-1:0]  bus_data,
    input logic [LANES-1:0]  bus_lanes,
    input logic              chk_en,
    input logic              span_err
);

    logic [3:0] nbytes;
    logic [5:0] end_off;

    assign nbytes  = (bus_size == 3'b000) ? 4'd8 : {1'b0, bus_size};
    assign end_off = {1'b0, bus_addr[4:0]} + {2'b00, nbytes};

    // R1: reset leaves nothing on the bus
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !bus_valid);

    // R4 / R2: size code, alignment and lanes agree
    p_size_lanes_r4: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> ((bus_size == 3'b000 && bus_lanes == 8'hFF && bus_addr[2:0] == 3'b000) ||
                       (bus_size == 3'b100 && bus_addr[1:0] == 2'b00 &&
                        ((!bus_addr[2] && bus_lanes == 8'hF0) || (bus_addr[2] && bus_lanes == 8'h0F)))));

    // R8: a stalled transfer stays put
    p_stall_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_size) &&
                                       $stable(bus_data) && $stable(bus_lanes)));

    // R9: no transfer runs past a 32-byte block
    p_no_cross_r9: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (end_off <= 6'd32));

    // R9: flag quiet when the check is off
    p_flag_gated_r9: assert property (@(posedge clk) disable iff (rst)
        !chk_en |-> !span_err);

    // R10: backpressure reaches the store side
    p_backpressure_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |-> !st_ready);

endmodule

bind cis_store_combiner cis_store_combiner_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .bus_valid(bus_valid),
    .bus_ready(bus_ready),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .bus_data (bus_data),
    .bus_lanes(bus_lanes),
    .chk_en   (chk_en),
    .span_err (span_err)
);

// File: tb/tb_cis_store_combiner.sv
module tb_cis_store_combiner;

    typedef struct {
        int          gap;
        logic [31:0] a;
        logic [31:0] d;
        bit          u;
        bit          m;
    } stim_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic        st_uncached = 1'b0;
    logic        st_multi = 1'b0;
    logic        bus_valid;
    logic        bus_ready = 1'b1;
    logic [31:0] bus_addr;
    logic [2:0]  bus_size;
    logic [63:0] bus_data;
    logic [7:0]  bus_lanes;
    logic        chk_en = 1'b1;
    logic        span_err;

    int checks = 0;
    int fails  = 0;
    int rdy_mode = 0; // 0 always ready, 1 random, 2 held low

    stim_t stim[$];
    stim_t cur;
    bit    cur_active = 0;
    int    gapcnt = 0;

    // recorded bus transfers
    logic [31:0] rec_a[$];
    logic [2:0]  rec_s[$];
    logic [63:0] rec_d[$];
    logic [7:0]  rec_l[$];

    // reference state
    bit          h_v = 0;
    logic [31:0] h_a, h_d;
    bit          o_v = 0;
    logic [31:0] o_a;
    logic [2:0]  o_s;
    logic [63:0] o_d;
    logic [7:0]  o_l;

    cis_store_combiner dut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data),
        .st_uncached(st_uncached), .st_multi(st_multi),
        .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_data(bus_data), .bus_lanes(bus_lanes),
        .chk_en(chk_en), .span_err(span_err)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] wdata(input logic [31:0] a, input logic [31:0] d);
        return a[2] ? {32'h0, d} : {d, 32'h0};
    endfunction

    function automatic logic [7:0] wlanes(input logic [31:0] a);
        return a[2] ? 8'h0F : 8'hF0;
    endfunction

    task automatic set_word(input logic [31:0] a, input logic [31:0] d);
        o_v = 1; o_a = {a[31:2], 2'b00}; o_s = 3'b100;
        o_d = wdata(a, d); o_l = wlanes(a);
    endtask

    // one clock of stimulus, comparison and reference update
    task automatic step();
        bit          sv, rdy, ofree, part, erdy;
        logic [31:0] ca;
        bit          p_stall;
        logic [31:0] p_a;
        logic [63:0] p_d;
        @(negedge clk);
        p_stall = bus_valid && !bus_ready;
        p_a = bus_addr; p_d = bus_data;
        if (!cur_active && stim.size() > 0) begin
            cur = stim.pop_front();
            cur_active = 1;
            gapcnt = cur.gap;
        end
        sv = cur_active && (gapcnt == 0);
        case (rdy_mode)
            0: rdy = 1;
            1: rdy = ($urandom_range(3) != 0);
            default: rdy = 0;
        endcase
        st_valid = sv;
        st_addr = cur.a; st_data = cur.d; st_uncached = cur.u; st_multi = cur.m;
        bus_ready = rdy;
        #1;
        ca = {cur.a[31:2], 2'b00};
        ofree = !o_v || rdy;
        part = h_v && sv && cur.u && cur.m && (ca == h_a + 32'd4);
        erdy = ofree && (!h_v || part);
        // R7: cycle-accurate comparison
        check(st_ready === erdy, "R10", "st_ready vs reference", {63'h0, st_ready}, {63'h0, erdy});
        check(bus_valid === o_v, "R7", "bus_valid vs reference", {63'h0, bus_valid}, {63'h0, o_v});
        if (o_v && bus_valid) begin
            check(bus_addr === o_a, "R7", "bus_addr", {32'h0, bus_addr}, {32'h0, o_a});
            check(bus_size === o_s, "R4", "bus_size", {61'h0, bus_size}, {61'h0, o_s});
            check(bus_data === o_d, "R7", "bus_data", bus_data, o_d);
            check(bus_lanes === o_l, "R4", "bus_lanes", {56'h0, bus_lanes}, {56'h0, o_l});
        end
        if (p_stall)
            check(bus_valid && bus_addr === p_a && bus_data === p_d, "R8", "stalled transfer moved",
                  bus_data, p_d);
        check(span_err === 1'b0, "R9", "span_err", {63'h0, span_err}, 64'h0);
        if (bus_valid && rdy) begin
            rec_a.push_back(bus_addr); rec_s.push_back(bus_size);
            rec_d.push_back(bus_data); rec_l.push_back(bus_lanes);
        end
        // reference update for the coming edge
        if (o_v && rdy) o_v = 0;
        if (ofree) begin
            if (h_v) begin
                if (part) begin
                    o_v = 1; o_a = h_a; o_s = 3'b000; o_d = {h_d, cur.d}; o_l = 8'hFF;
                end else begin
                    set_word(h_a, h_d);
                end
                h_v = 0;
            end else if (sv) begin
                if (cur.u && cur.m && !cur.a[2]) begin
                    h_v = 1; h_a = ca; h_d = cur.d;
                end else begin
                    set_word(cur.a, cur.d);
                end
            end
        end
        if (sv && erdy) cur_active = 0;
        else if (cur_active && gapcnt > 0) gapcnt--;
    endtask

    task automatic push_st(input int gap, input logic [31:0] a, input logic [31:0] d,
                           input bit u, input bit m);
        stim_t s;
        s.gap = gap; s.a = a; s.d = d; s.u = u; s.m = m;
        stim.push_back(s);
    endtask

    task automatic drain();
        int n = 0;
        while ((stim.size() > 0 || cur_active || h_v || o_v) && n < 5000) begin
            step();
            n++;
        end
        repeat (3) step();
    endtask

    task automatic expect_xfer(input string req, input logic [31:0] a, input logic [2:0] s,
                               input logic [63:0] d, input logic [7:0] l);
        if (rec_a.size() == 0) begin
            check(0, req, "missing transfer at address", 64'h0, {32'h0, a});
        end else begin
            logic [31:0] ra = rec_a.pop_front();
            logic [2:0]  rs = rec_s.pop_front();
            logic [63:0] rd = rec_d.pop_front();
            logic [7:0]  rl = rec_l.pop_front();
            check(ra === a && rs === s && rl === l, req, "transfer addr/size/lanes",
                  {ra, 21'h0, rs, rl}, {a, 21'h0, s, l});
            check(rd === d, req, "transfer data", rd, d);
        end
    endtask

    task automatic expect_empty(input string req);
        check(rec_a.size() == 0, req, "extra transfers", 64'(rec_a.size()), 64'h0);
        rec_a.delete(); rec_s.delete(); rec_d.delete(); rec_l.delete();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(10 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(bus_valid === 1'b0, "R1", "bus_valid after reset", {63'h0, bus_valid}, 64'h0);
        check(st_ready === 1'b1, "R1", "st_ready after reset", {63'h0, st_ready}, 64'h1);

        // R2: aligned uncached multiple-word pair merges
        push_st(0, 32'h100, 32'hA1A1A1A1, 1, 1);
        push_st(0, 32'h104, 32'hB2B2B2B2, 1, 1);
        drain();
        expect_xfer("R2", 32'h100, 3'b000, 64'hA1A1A1A1_B2B2B2B2, 8'hFF);
        expect_empty("R2");

        // R6: partner one cycle late, held word leaves alone
        push_st(0, 32'h108, 32'h11111111, 1, 1);
        push_st(1, 32'h10C, 32'h22222222, 1, 1);
        drain();
        expect_xfer("R6", 32'h108, 3'b100, 64'h11111111_00000000, 8'hF0);
        expect_xfer("R4", 32'h10C, 3'b100, 64'h00000000_22222222, 8'h0F);
        expect_empty("R6");

        // R3: cached pair, then uncached single stores
        push_st(0, 32'h200, 32'h33333333, 0, 1);
        push_st(0, 32'h204, 32'h44444444, 0, 1);
        push_st(0, 32'h208, 32'h55555555, 1, 0);
        push_st(0, 32'h20E, 32'h66666666, 1, 0);
        drain();
        expect_xfer("R3", 32'h200, 3'b100, 64'h33333333_00000000, 8'hF0);
        expect_xfer("R3", 32'h204, 3'b100, 64'h00000000_44444444, 8'h0F);
        expect_xfer("R3", 32'h208, 3'b100, 64'h55555555_00000000, 8'hF0);
        expect_xfer("R4", 32'h20C, 3'b100, 64'h00000000_66666666, 8'h0F);
        expect_empty("R3");

        // R5: odd slot first, then an aligned pair
        push_st(0, 32'h304, 32'h77777777, 1, 1);
        push_st(0, 32'h308, 32'h88888888, 1, 1);
        push_st(0, 32'h30C, 32'h99999999, 1, 1);
        drain();
        expect_xfer("R5", 32'h304, 3'b100, 64'h00000000_77777777, 8'h0F);
        expect_xfer("R5", 32'h308, 3'b000, 64'h88888888_99999999, 8'hFF);
        expect_empty("R5");

        // R6 / R7: non-adjacent aligned words keep order
        push_st(0, 32'h400, 32'hC0C0C0C0, 1, 1);
        push_st(0, 32'h408, 32'hD0D0D0D0, 1, 1);
        drain();
        expect_xfer("R7", 32'h400, 3'b100, 64'hC0C0C0C0_00000000, 8'hF0);
        expect_xfer("R7", 32'h408, 3'b100, 64'hD0D0D0D0_00000000, 8'hF0);
        expect_empty("R7");

        // R9: words on either side of a 32-byte boundary stay apart
        push_st(0, 32'h41C, 32'hE1E1E1E1, 1, 1);
        push_st(0, 32'h420, 32'hE2E2E2E2, 1, 1);
        drain();
        expect_xfer("R9", 32'h41C, 3'b100, 64'h00000000_E1E1E1E1, 8'h0F);
        expect_xfer("R9", 32'h420, 3'b100, 64'hE2E2E2E2_00000000, 8'hF0);
        expect_empty("R9");

        // R10 / R8: bus held off
        rdy_mode = 2;
        push_st(0, 32'h500, 32'h0A0A0A0A, 1, 1);
        push_st(0, 32'h504, 32'h0B0B0B0B, 1, 1);
        push_st(0, 32'h600, 32'h0C0C0C0C, 0, 0);
        repeat (6) step();
        check(bus_valid === 1'b1 && bus_size === 3'b000, "R8", "stalled merged transfer",
              {60'h0, bus_valid, bus_size}, {60'h0, 1'b1, 3'b000});
        check(st_ready === 1'b0, "R10", "store blocked under backpressure",
              {63'h0, st_ready}, 64'h0);
        rdy_mode = 0;
        drain();
        expect_xfer("R8", 32'h500, 3'b000, 64'h0A0A0A0A_0B0B0B0B, 8'hFF);
        expect_xfer("R10", 32'h600, 3'b100, 64'h0C0C0C0C_00000000, 8'hF0);
        expect_empty("R10");

        // R7: mixed runs with random backpressure against the reference
        rdy_mode = 1;
        void'($urandom(32'h5EED));
        for (int r = 0; r < 60; r++) begin
            logic [31:0] base = {20'h0, 7'($urandom_range(127)), 5'h0}
                                + 32'($urandom_range(7)) * 4;
            bit u = ($urandom_range(3) != 0);
            bit m = ($urandom_range(3) != 0);
            int len = $urandom_range(1, 5);
            for (int k = 0; k < len; k++)
                push_st(($urandom_range(5) == 0) ? 1 : 0, base + 32'(k * 4), $urandom(), u, m);
        end
        drain();
        rec_a.delete(); rec_s.delete(); rec_d.delete(); rec_l.delete();

        finish_run();
    end

endmodule